// File: doc/BRIEF.md
# Mixed-Sign Multiplier Unit

This unit forms a 32-bit product from two 16-bit operands, or from one 16-bit operand and a 5-bit unsigned literal, under a 3-bit mode code. The code sets whether each operand counts as signed or unsigned. It also sets whether the second factor comes from the literal input, and whether only the low bytes take part.

Each factor is widened to 17 bits. A signed factor copies its top bit into the new bit. An unsigned factor gets a zero there. One 17x17 signed multiply then serves every sign combination. The low 32 bits of the result are captured in a register on a clock edge where `in_valid` is high. `prod_valid` goes high one cycle later.

Top module: `mixsign_mul`

## Requirements
- R1: While reset is asserted and after it is released, with no accepted input yet, `product` is 0 and `prod_valid` is 0.
- R2: `prod_valid` is high in exactly the cycle after a cycle in which `in_valid` was high at the clock edge.
- R3: A clock edge with `in_valid` low leaves `product` unchanged, whatever the operands and mode are.
- R4: Mode 0 treats `op_a` as signed and `op_b` as signed. `product` is their two's complement product.
- R5: Mode 1 treats `op_a` as unsigned and `op_b` as unsigned. `product` is their unsigned product.
- R6: Mode 2 treats `op_a` as unsigned and `op_b` as signed. `product` is the product in two's complement.
- R7: Mode 3 treats `op_a` as signed and `op_b` as unsigned. `product` is the product in two's complement.
- R8: Mode 4 multiplies signed `op_a` by the unsigned 5-bit `op_lit`. `op_b` has no effect.
- R9: Mode 5 multiplies unsigned `op_a` by the unsigned 5-bit `op_lit`. `op_b` has no effect.
- R10: Mode 6 multiplies the unsigned low bytes `op_a[7:0]` and `op_b[7:0]`. Bits [15:8] of both operands have no effect.
- R11: Mode 7 is unused and always yields a product of 0.
- R12: `product` is the low 32 bits of the 34-bit signed core result. For every mode that result fits in 33 bits, so no product is lost to truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and mode are accepted at this edge |
| mode | input | 3 | Mode code 0..7 |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| op_lit | input | 5 | Unsigned literal, used in modes 4 and 5 |
| product | output | 32 | Registered product |
| prod_valid | output | 1 | Product was updated on the previous edge |

## Verification
The register-operand modes are swept over a cross product of edge values: 0, 1, 2, both signed extremes, -1, a byte-only value, a high-byte-only value and an irregular value. This shows whether the top bit was read as sign or magnitude in each mode, and whether a negative factor wraps the result correctly.

The literal modes pair every literal from 0 to 31 with each edge value while `op_b` carries noise. A wrong operand selection or a sign-extended literal then shows up as a mismatch. The byte mode uses operands whose high bytes are not zero, so any leak of those bits shows up. Idle cycles with changed operands show whether the register holds its value and whether the strobe drops.

// File: rtl/mixmul_pkg.sv
package mixmul_pkg;

  typedef enum logic [2:0] {
    MODE_SS     = 3'd0,
    MODE_UU     = 3'd1,
    MODE_UA_SB  = 3'd2,
    MODE_SA_UB  = 3'd3,
    MODE_S_LIT  = 3'd4,
    MODE_U_LIT  = 3'd5,
    MODE_BYTE   = 3'd6,
    MODE_NONE   = 3'd7
  } mul_mode_e;

  // How one factor is widened before the signed core
  typedef enum logic [2:0] {
    EXT_SIGN,
    EXT_ZERO,
    EXT_LOW_BYTE,
    EXT_LIT,
    EXT_KILL
  } ext_sel_e;

  typedef struct packed {
    ext_sel_e a;
    ext_sel_e b;
  } ext_plan_t;

  function automatic ext_plan_t plan_for(input logic [2:0] code);
    ext_plan_t p;
    case (code)
      MODE_SS:    p = '{a: EXT_SIGN,     b: EXT_SIGN};
      MODE_UU:    p = '{a: EXT_ZERO,     b: EXT_ZERO};
      MODE_UA_SB: p = '{a: EXT_ZERO,     b: EXT_SIGN};
      MODE_SA_UB: p = '{a: EXT_SIGN,     b: EXT_ZERO};
      MODE_S_LIT: p = '{a: EXT_SIGN,     b: EXT_LIT};
      MODE_U_LIT: p = '{a: EXT_ZERO,     b: EXT_LIT};
      MODE_BYTE:  p = '{a: EXT_LOW_BYTE, b: EXT_LOW_BYTE};
      default:    p = '{a: EXT_KILL,     b: EXT_KILL};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/mixmul_widen.sv
module mixmul_widen
  import mixmul_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LIT_W  = 5,
  parameter int BYTE_W = 8,
  localparam int EXT_W = DATA_W + 1
) (
  input  logic [DATA_W-1:0] data,
  input  logic [LIT_W-1:0]  lit,
  input  ext_sel_e          sel,
  output logic [EXT_W-1:0]  wide
);

  always_comb begin
    wide = '0;
    case (sel)
      EXT_SIGN:     wide = {data[DATA_W-1], data};
      EXT_ZERO:     wide = {1'b0, data};
      EXT_LOW_BYTE: wide[BYTE_W-1:0] = data[BYTE_W-1:0];
      EXT_LIT:      wide[LIT_W-1:0] = lit;
      default:      wide = '0;
    endcase
  end

endmodule

// File: rtl/mixmul_core.sv
module mixmul_core #(
  parameter int EXT_W = 17,
  localparam int CORE_W = 2 * EXT_W
) (
  input  logic [EXT_W-1:0]  a,
  input  logic [EXT_W-1:0]  b,
  output logic [CORE_W-1:0] p
);

  logic signed [CORE_W-1:0] sa, sb;

  always_comb begin
    sa = CORE_W'($signed(a));
    sb = CORE_W'($signed(b));
    p  = sa * sb;
  end

endmodule

// File: rtl/mixsign_mul.sv
module mixsign_mul
  import mixmul_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LIT_W  = 5,
  parameter int BYTE_W = 8,
  localparam int EXT_W  = DATA_W + 1,
  localparam int CORE_W = 2 * EXT_W,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        mode,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [LIT_W-1:0]  op_lit,
  output logic [PROD_W-1:0] product,
  output logic              prod_valid
);

  ext_plan_t plan;
  assign plan = plan_for(mode);

  logic [DATA_W-1:0] src [2];
  ext_sel_e          sel [2];
  logic [EXT_W-1:0]  ext [2];

  assign src[0] = op_a;
  assign src[1] = op_b;
  assign sel[0] = plan.a;
  assign sel[1] = plan.b;

  for (genvar g = 0; g < 2; g++) begin : g_widen
    mixmul_widen #(.DATA_W(DATA_W), .LIT_W(LIT_W), .BYTE_W(BYTE_W)) u_widen (
      .data (src[g]),
      .lit  (op_lit),
      .sel  (sel[g]),
      .wide (ext[g])
    );
  end

  // Named internal events for the checks below
  logic [EXT_W-1:0]  a_ext, b_ext;
  logic [CORE_W-1:0] core_p;
  assign a_ext = ext[0];
  assign b_ext = ext[1];

  mixmul_core #(.EXT_W(EXT_W)) u_core (
    .a (a_ext),
    .b (b_ext),
    .p (core_p)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      product    <= '0;
      prod_valid <= 1'b0;
    end else begin
      prod_valid <= in_valid;
      if (in_valid) product <= core_p[PROD_W-1:0];
    end
  end

  a_r2_strobe_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> prod_valid);
  a_r2_strobe_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !prod_valid);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product));
  a_r4_sign_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SS) |-> (a_ext[EXT_W-1] == op_a[DATA_W-1] && b_ext[EXT_W-1] == op_b[DATA_W-1]));
  a_r5_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_UU) |-> (!a_ext[EXT_W-1] && !b_ext[EXT_W-1]));
  a_r8_lit_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_S_LIT || mode == MODE_U_LIT) |-> (b_ext == EXT_W'(op_lit)));
  a_r10_byte_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BYTE) |-> (a_ext[EXT_W-1:BYTE_W] == '0 && b_ext[EXT_W-1:BYTE_W] == '0));
  a_r11_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_NONE) |=> (product == '0));
  a_r12_fits: assert property (@(posedge clk) disable iff (!rst_n)
    core_p[CORE_W-1] == core_p[CORE_W-2]);

endmodule

// File: tb/mixsign_mul_test.sv
module mixsign_mul_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [4:0]  op_lit = '0;
  logic [31:0] product;
  logic        prod_valid;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  mixsign_mul uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .op_a(op_a), .op_b(op_b), .op_lit(op_lit),
    .product(product), .prod_valid(prod_valid)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h (mode=%0d a=%h b=%h lit=%0d)", req, got, exp, mode, op_a, op_b, op_lit);
    end
  endtask

  function automatic longint as_signed(input logic [15:0] v);
    return v[15] ? longint'(v) - 65536 : longint'(v);
  endfunction

  function automatic logic [31:0] model(input logic [2:0] m, input logic [15:0] a,
                                        input logic [15:0] b, input logic [4:0] l);
    longint x, y;
    logic [63:0] p;
    case (m)
      3'd0: begin x = as_signed(a); y = as_signed(b); end
      3'd1: begin x = longint'(a);  y = longint'(b);  end
      3'd2: begin x = longint'(a);  y = as_signed(b); end
      3'd3: begin x = as_signed(a); y = longint'(b);  end
      3'd4: begin x = as_signed(a); y = longint'(l);  end
      3'd5: begin x = longint'(a);  y = longint'(l);  end
      3'd6: begin x = longint'(a[7:0]); y = longint'(b[7:0]); end
      default: begin x = 0; y = 0; end
    endcase
    p = 64'(x * y);
    return p[31:0];
  endfunction

  string tag [8] = '{"R4", "R5", "R6", "R7", "R8", "R9", "R10", "R11"};
  logic [15:0] edges [10] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000,
                              16'h8001, 16'hFFFF, 16'h00FF, 16'hFF00, 16'h5A3C};

  task automatic apply(input logic [2:0] m, input logic [15:0] a,
                       input logic [15:0] b, input logic [4:0] l);
    @(negedge clk);
    mode = m; op_a = a; op_b = b; op_lit = l; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag[m], product, model(m, a, b, l));
    check("R2", 32'(prod_valid), 32'd1);
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check("R1", product, 32'd0);
    check("R1", 32'(prod_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", product, 32'd0);
    check("R1", 32'(prod_valid), 32'd0);

    // register-operand modes and the unused code
    for (int m = 0; m < 8; m++) begin
      if (m == 4 || m == 5) continue;
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          apply(3'(m), edges[i], edges[j], 5'(i * 3 + j));
    end

    // literal modes: op_b carries noise; R8 R9
    for (int m = 4; m < 6; m++)
      for (int i = 0; i < 10; i++)
        for (int l = 0; l < 32; l++)
          apply(3'(m), edges[i], ~edges[i] ^ 16'(l * 16'h0911), 5'(l));

    // byte mode, high bytes full of noise; R10
    for (int i = 0; i < 256; i += 17)
      apply(3'd6, {8'hA5, 8'(i)}, {8'(i * 7), 8'(255 - i)}, 5'd0);

    // R12 extremes that need the full 32-bit width
    apply(3'd1, 16'hFFFF, 16'hFFFF, 5'd0);
    apply(3'd2, 16'hFFFF, 16'h8000, 5'd0);
    apply(3'd0, 16'h8000, 16'h8000, 5'd0);

    // R3 hold with changed inputs while idle, and R2 strobe low
    apply(3'd0, 16'h1234, 16'hFFFE, 5'd0);
    held = product;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      mode = 3'(k); op_a = 16'(k * 16'h3C1D); op_b = ~op_a; op_lit = 5'(k * 5);
      @(negedge clk);
      check("R3", product, held);
      check("R2", 32'(prod_valid), 32'd0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule